// File: doc/BRIEF.md
# Per-Bank DRAM Request Selector with Row-Hit Bypass

This block chooses, once per clock, which queued request a single DRAM bank should serve next. It looks at the bank's read slots and write slots, the row that is currently open in the bank, and the cycle at which that row was activated. From these it picks an oldest-first candidate. When the bank is in write-drain mode the candidate is a write. Otherwise it is a read, and a read that hits the open row may jump ahead of an older read that misses it. That jump is only allowed when it cannot delay the bank's earliest legal precharge.

The block also works out the first DRAM command the chosen request needs: activate, precharge, read or write. A per-command readiness flag from the timing checker then gates the choice, so a request is only named when its first command could issue now. The result is held in a register and drives a command builder in the next cycle. Slot 0 of each queue is the oldest entry, and age falls as the slot index rises.

The registered path state is one of four values. PATH_NONE means nothing is selected. PATH_WRITE means a write was granted. PATH_READ_OLD means the oldest read was granted. PATH_READ_HIT means a younger row-hit read was granted in place of the oldest read. Every cycle the next path is worked out from the inputs. Any path moves to PATH_NONE when the bank is busy, when both queues are empty, or when the candidate's first command is not ready. Any path moves to PATH_WRITE when a write is granted under drain mode. Any path moves to PATH_READ_OLD or PATH_READ_HIT when a read is granted.

Top module: `bank_req_picker`

## Requirements
- R1: While `cmdq_busy` is 1, the next cycle shows `sel_valid` = 0.
- R2: When no read slot and no write slot is valid, the next cycle shows `sel_valid` = 0.
- R3: With `drain_mode` = 1 and at least one valid write slot, the candidate is the valid write with the lowest slot index. It is selected only if its first command is ready. Otherwise nothing is selected, and no read is taken in its place.
- R4: With `drain_mode` = 1 and no valid write, a read may be selected only when `cfg_read_bypass` = 1. Otherwise nothing is selected.
- R5: With `drain_mode` = 0 a write is never selected. With no valid read, nothing is selected.
- R6: The default read candidate is the valid read with the lowest slot index.
- R7: With `cfg_hit_bypass` = 1, the read candidate is replaced by the lowest-index valid read whose row equals `open_row`. This happens only when `row_open` = 1, the default read misses the open row, and the window of R8 holds.
- R8: The bypass window holds when `now_cyc + t_rtp <= act_ts + t_ras`. Both sums are formed one bit wider than the counters, so there is no wrap, and equality is allowed.
- R9: The first command of the candidate is encoded on `sel_cmd` as 0 = activate (bank closed), 1 = precharge (another row open), 2 = read, or 3 = write (its row is open).
- R10: A candidate is selected only if the readiness flag matching its first command (`can_act`, `can_pre`, `can_rd`, `can_wr`) is 1.
- R11: Outputs are registered: they reflect the inputs sampled at the previous rising edge. During reset, and whenever `sel_valid` = 0, all outputs are 0.
- R12: `sel_bypass` = 1 exactly when the selected request is a row-hit read that replaced the default read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdq_busy | input | 1 | Bank still holds outstanding commands |
| drain_mode | input | 1 | Write-drain mode active |
| cfg_read_bypass | input | 1 | Reads allowed in drain mode when no write is valid |
| cfg_hit_bypass | input | 1 | Enable row-hit bypass |
| rd_valid | input | RQ_DEPTH | Read slot valid bits, slot 0 oldest |
| rd_row | input | RQ_DEPTH*ROW_W | Row of each read slot, slot i at bits i*ROW_W |
| wr_valid | input | WQ_DEPTH | Write slot valid bits, slot 0 oldest |
| wr_row | input | WQ_DEPTH*ROW_W | Row of each write slot |
| row_open | input | 1 | Bank has an open row |
| open_row | input | ROW_W | Currently open row |
| act_ts | input | TS_W | Cycle of the last activate |
| now_cyc | input | TS_W | Current cycle count |
| t_ras | input | TS_W | Activate-to-precharge minimum |
| t_rtp | input | TS_W | Read-to-precharge minimum |
| can_act | input | 1 | Activate could issue now |
| can_pre | input | 1 | Precharge could issue now |
| can_rd | input | 1 | Read could issue now |
| can_wr | input | 1 | Write could issue now |
| sel_valid | output | 1 | A request is selected |
| sel_is_write | output | 1 | Selected request comes from the write queue |
| sel_idx | output | IDX_W | Slot index of the selected request |
| sel_cmd | output | 2 | First command of the selected request |
| sel_bypass | output | 1 | Row-hit bypass was taken |

## Verification
The hardest case to reach is a row-hit bypass right at the edge of the timing window. It needs an older read that misses the open row, a younger read that hits it, bypass enabled, and `now_cyc + t_rtp` equal to `act_ts + t_ras` or one cycle past it. The same edge also matters when the sums cross the counter width. Random stimulus draws rows from a four-value set so that hits and misses mix often, and it sets the activate stamp a short distance behind the current cycle so the window often lands near its edge. Directed steps then hit the exact equality, the case one cycle late, and a case that wraps the counter.

// File: rtl/bank_pick_pkg.sv
package bank_pick_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_PRE = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } first_cmd_e;

    typedef enum logic [1:0] {
        PATH_NONE     = 2'd0,
        PATH_WRITE    = 2'd1,
        PATH_READ_OLD = 2'd2,
        PATH_READ_HIT = 2'd3
    } pick_path_e;

endpackage

// File: rtl/oldest_slot.sv
module oldest_slot #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  valid,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |valid;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/row_match.sv
module row_match #(
    parameter int N     = 8,
    parameter int ROW_W = 8
) (
    input  logic [N*ROW_W-1:0] rows,
    input  logic [N-1:0]       valid,
    input  logic               row_open,
    input  logic [ROW_W-1:0]   open_row,
    output logic [N-1:0]       hit_mask
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_mask[g] = valid[g] && row_open &&
                             (rows[g*ROW_W +: ROW_W] == open_row);
    end
endmodule

// File: rtl/first_cmd_dec.sv
module first_cmd_dec
    import bank_pick_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic             row_open,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] req_row,
    input  logic             req_is_write,
    input  logic             can_act,
    input  logic             can_pre,
    input  logic             can_rd,
    input  logic             can_wr,
    output first_cmd_e       cmd,
    output logic             ready
);
    always_comb begin
        if (!row_open) begin
            cmd = CMD_ACT;
        end else if (req_row != open_row) begin
            cmd = CMD_PRE;
        end else if (req_is_write) begin
            cmd = CMD_WR;
        end else begin
            cmd = CMD_RD;
        end
    end

    always_comb begin
        unique case (cmd)
            CMD_ACT: ready = can_act;
            CMD_PRE: ready = can_pre;
            CMD_RD:  ready = can_rd;
            CMD_WR:  ready = can_wr;
            default: ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/bank_req_picker.sv
module bank_req_picker
    import bank_pick_pkg::*;
#(
    parameter int RQ_DEPTH = 8,
    parameter int WQ_DEPTH = 8,
    parameter int ROW_W    = 8,
    parameter int TS_W     = 16,
    localparam int IW_RD   = (RQ_DEPTH > 1) ? $clog2(RQ_DEPTH) : 1,
    localparam int IW_WR   = (WQ_DEPTH > 1) ? $clog2(WQ_DEPTH) : 1,
    localparam int IDX_W   = (IW_RD > IW_WR) ? IW_RD : IW_WR
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmdq_busy,
    input  logic                      drain_mode,
    input  logic                      cfg_read_bypass,
    input  logic                      cfg_hit_bypass,
    input  logic [RQ_DEPTH-1:0]       rd_valid,
    input  logic [RQ_DEPTH*ROW_W-1:0] rd_row,
    input  logic [WQ_DEPTH-1:0]       wr_valid,
    input  logic [WQ_DEPTH*ROW_W-1:0] wr_row,
    input  logic                      row_open,
    input  logic [ROW_W-1:0]          open_row,
    input  logic [TS_W-1:0]           act_ts,
    input  logic [TS_W-1:0]           now_cyc,
    input  logic [TS_W-1:0]           t_ras,
    input  logic [TS_W-1:0]           t_rtp,
    input  logic                      can_act,
    input  logic                      can_pre,
    input  logic                      can_rd,
    input  logic                      can_wr,
    output logic                      sel_valid,
    output logic                      sel_is_write,
    output logic [IDX_W-1:0]          sel_idx,
    output logic [1:0]                sel_cmd,
    output logic                      sel_bypass
);

    // slot row views
    logic [ROW_W-1:0] rd_rows [RQ_DEPTH];
    logic [ROW_W-1:0] wr_rows [WQ_DEPTH];

    for (genvar g = 0; g < RQ_DEPTH; g++) begin : g_rd_rows
        assign rd_rows[g] = rd_row[g*ROW_W +: ROW_W];
    end
    for (genvar g = 0; g < WQ_DEPTH; g++) begin : g_wr_rows
        assign wr_rows[g] = wr_row[g*ROW_W +: ROW_W];
    end

    // oldest-first candidates
    logic             rd_any, wr_any, hit_any;
    logic [IW_RD-1:0] rd_old_idx, rd_hit_idx;
    logic [IW_WR-1:0] wr_old_idx;
    logic [RQ_DEPTH-1:0] rd_hit_mask;

    oldest_slot #(.N(RQ_DEPTH), .IW(IW_RD)) u_rd_oldest (
        .valid (rd_valid),
        .found (rd_any),
        .idx   (rd_old_idx)
    );

    oldest_slot #(.N(WQ_DEPTH), .IW(IW_WR)) u_wr_oldest (
        .valid (wr_valid),
        .found (wr_any),
        .idx   (wr_old_idx)
    );

    row_match #(.N(RQ_DEPTH), .ROW_W(ROW_W)) u_rd_match (
        .rows     (rd_row),
        .valid    (rd_valid),
        .row_open (row_open),
        .open_row (open_row),
        .hit_mask (rd_hit_mask)
    );

    oldest_slot #(.N(RQ_DEPTH), .IW(IW_RD)) u_rd_hit (
        .valid (rd_hit_mask),
        .found (hit_any),
        .idx   (rd_hit_idx)
    );

    // bypass window, one bit wider than the counters
    logic [TS_W:0] pre_limit, pre_spec;
    logic          win_ok, old_is_hit, use_hit;

    assign pre_limit  = {1'b0, act_ts}  + {1'b0, t_ras};
    assign pre_spec   = {1'b0, now_cyc} + {1'b0, t_rtp};
    assign win_ok     = (pre_spec <= pre_limit);
    assign old_is_hit = rd_hit_mask[rd_old_idx];
    assign use_hit    = cfg_hit_bypass && !old_is_hit && hit_any && win_ok;

    // path choice
    pick_path_e path_nxt, path_q;

    always_comb begin
        path_nxt = PATH_NONE;
        if (!cmdq_busy && (rd_any || wr_any)) begin
            if (drain_mode && wr_any) begin
                path_nxt = PATH_WRITE;
            end else if (!drain_mode || cfg_read_bypass) begin
                if (rd_any) begin
                    path_nxt = use_hit ? PATH_READ_HIT : PATH_READ_OLD;
                end
            end
        end
    end

    // candidate mux
    logic [ROW_W-1:0] cand_row;
    logic [IDX_W-1:0] cand_idx;
    logic             cand_wr;

    always_comb begin
        unique case (path_nxt)
            PATH_WRITE: begin
                cand_row = wr_rows[wr_old_idx];
                cand_idx = IDX_W'(wr_old_idx);
                cand_wr  = 1'b1;
            end
            PATH_READ_HIT: begin
                cand_row = rd_rows[rd_hit_idx];
                cand_idx = IDX_W'(rd_hit_idx);
                cand_wr  = 1'b0;
            end
            PATH_READ_OLD: begin
                cand_row = rd_rows[rd_old_idx];
                cand_idx = IDX_W'(rd_old_idx);
                cand_wr  = 1'b0;
            end
            default: begin
                cand_row = '0;
                cand_idx = '0;
                cand_wr  = 1'b0;
            end
        endcase
    end

    first_cmd_e cand_cmd;
    logic       cand_ready;

    first_cmd_dec #(.ROW_W(ROW_W)) u_dec (
        .row_open     (row_open),
        .open_row     (open_row),
        .req_row      (cand_row),
        .req_is_write (cand_wr),
        .can_act      (can_act),
        .can_pre      (can_pre),
        .can_rd       (can_rd),
        .can_wr       (can_wr),
        .cmd          (cand_cmd),
        .ready        (cand_ready)
    );

    logic grant;
    assign grant = (path_nxt != PATH_NONE) && cand_ready;

    // state register
    logic [IDX_W-1:0] idx_q;
    first_cmd_e       cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_q <= PATH_NONE;
            idx_q  <= '0;
            cmd_q  <= CMD_ACT;
        end else if (grant) begin
            path_q <= path_nxt;
            idx_q  <= cand_idx;
            cmd_q  <= cand_cmd;
        end else begin
            path_q <= PATH_NONE;
            idx_q  <= '0;
            cmd_q  <= CMD_ACT;
        end
    end

    // outputs
    always_comb begin
        sel_idx = idx_q;
        sel_cmd = cmd_q;
        unique case (path_q)
            PATH_WRITE: begin
                sel_valid    = 1'b1;
                sel_is_write = 1'b1;
                sel_bypass   = 1'b0;
            end
            PATH_READ_OLD: begin
                sel_valid    = 1'b1;
                sel_is_write = 1'b0;
                sel_bypass   = 1'b0;
            end
            PATH_READ_HIT: begin
                sel_valid    = 1'b1;
                sel_is_write = 1'b0;
                sel_bypass   = 1'b1;
            end
            default: begin
                sel_valid    = 1'b0;
                sel_is_write = 1'b0;
                sel_bypass   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bank_req_picker_chk.sv
module bank_req_picker_chk
    import bank_pick_pkg::*;
#(
    parameter int RQ_DEPTH = 8,
    parameter int WQ_DEPTH = 8,
    parameter int TS_W     = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmdq_busy,
    input logic                drain_mode,
    input logic                cfg_read_bypass,
    input logic                cfg_hit_bypass,
    input logic [RQ_DEPTH-1:0] rd_valid,
    input logic [WQ_DEPTH-1:0] wr_valid,
    input logic [TS_W-1:0]     act_ts,
    input logic [TS_W-1:0]     now_cyc,
    input logic [TS_W-1:0]     t_ras,
    input logic [TS_W-1:0]     t_rtp,
    input logic                can_act,
    input logic                can_pre,
    input logic                can_rd,
    input logic                can_wr,
    input logic                sel_valid,
    input logic                sel_is_write,
    input logic [1:0]          sel_cmd,
    input logic                sel_bypass
);

    a_r1_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmdq_busy |=> !sel_valid);

    a_r2_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid == '0 && wr_valid == '0) |=> !sel_valid);

    a_r3_drain_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_mode && wr_valid != '0) |=> (!sel_valid || sel_is_write));

    a_r4_drain_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_mode && wr_valid == '0 && !cfg_read_bypass) |=> !sel_valid);

    a_r5_no_write_normal: assert property (@(posedge clk) disable iff (!rst_n)
        !drain_mode |=> !(sel_valid && sel_is_write));

    a_r8_bypass_window: assert property (@(posedge clk) disable iff (!rst_n)
        sel_bypass |-> ($past(cfg_hit_bypass) &&
            (({1'b0, $past(now_cyc)} + {1'b0, $past(t_rtp)}) <=
             ({1'b0, $past(act_ts)}  + {1'b0, $past(t_ras)}))));

    a_r10_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ((sel_cmd == CMD_ACT && $past(can_act)) ||
                       (sel_cmd == CMD_PRE && $past(can_pre)) ||
                       (sel_cmd == CMD_RD  && $past(can_rd))  ||
                       (sel_cmd == CMD_WR  && $past(can_wr))));

    a_r12_bypass_is_hit_read: assert property (@(posedge clk) disable iff (!rst_n)
        sel_bypass |-> (sel_valid && !sel_is_write && sel_cmd == CMD_RD));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (!sel_is_write && !sel_bypass && sel_cmd == 2'd0));

endmodule

bind bank_req_picker bank_req_picker_chk #(
    .RQ_DEPTH (RQ_DEPTH),
    .WQ_DEPTH (WQ_DEPTH),
    .TS_W     (TS_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmdq_busy       (cmdq_busy),
    .drain_mode      (drain_mode),
    .cfg_read_bypass (cfg_read_bypass),
    .cfg_hit_bypass  (cfg_hit_bypass),
    .rd_valid        (rd_valid),
    .wr_valid        (wr_valid),
    .act_ts          (act_ts),
    .now_cyc         (now_cyc),
    .t_ras           (t_ras),
    .t_rtp           (t_rtp),
    .can_act         (can_act),
    .can_pre         (can_pre),
    .can_rd          (can_rd),
    .can_wr          (can_wr),
    .sel_valid       (sel_valid),
    .sel_is_write    (sel_is_write),
    .sel_cmd         (sel_cmd),
    .sel_bypass      (sel_bypass)
);

// File: tb/bank_req_picker_tb.sv
module bank_req_picker_tb;

    localparam int RQ = 8;
    localparam int WQ = 8;
    localparam int RW = 8;
    localparam int TW = 16;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic cmdq_busy, drain_mode, cfg_read_bypass, cfg_hit_bypass;
    logic [RQ-1:0]    rd_valid;
    logic [RQ*RW-1:0] rd_row;
    logic [WQ-1:0]    wr_valid;
    logic [WQ*RW-1:0] wr_row;
    logic             row_open;
    logic [RW-1:0]    open_row;
    logic [TW-1:0]    act_ts, now_cyc, t_ras, t_rtp;
    logic             can_act, can_pre, can_rd, can_wr;
    logic             sel_valid, sel_is_write, sel_bypass;
    logic [IW-1:0]    sel_idx;
    logic [1:0]       sel_cmd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bank_req_picker #(.RQ_DEPTH(RQ), .WQ_DEPTH(WQ), .ROW_W(RW), .TS_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmdq_busy(cmdq_busy), .drain_mode(drain_mode),
        .cfg_read_bypass(cfg_read_bypass), .cfg_hit_bypass(cfg_hit_bypass),
        .rd_valid(rd_valid), .rd_row(rd_row), .wr_valid(wr_valid), .wr_row(wr_row),
        .row_open(row_open), .open_row(open_row), .act_ts(act_ts), .now_cyc(now_cyc),
        .t_ras(t_ras), .t_rtp(t_rtp), .can_act(can_act), .can_pre(can_pre),
        .can_rd(can_rd), .can_wr(can_wr), .sel_valid(sel_valid),
        .sel_is_write(sel_is_write), .sel_idx(sel_idx), .sel_cmd(sel_cmd),
        .sel_bypass(sel_bypass)
    );

    // expected outputs
    logic       e_valid, e_wr, e_byp;
    logic [1:0] e_cmd;
    logic [IW-1:0] e_idx;
    string      e_tag;

    function automatic logic [1:0] exp_cmd(input logic [RW-1:0] r, input logic is_wr);
        if (!row_open) return 2'd0;
        if (r != open_row) return 2'd1;
        return is_wr ? 2'd3 : 2'd2;
    endfunction

    function automatic logic exp_ready(input logic [1:0] c);
        case (c)
            2'd0: return can_act;
            2'd1: return can_pre;
            2'd2: return can_rd;
            default: return can_wr;
        endcase
    endfunction

    task automatic model();
        int old_i, hit_i, w_i;
        logic [TW:0] lim, spec;
        logic [1:0] c;
        e_valid = 0; e_wr = 0; e_byp = 0; e_cmd = 0; e_idx = 0;
        old_i = -1; hit_i = -1; w_i = -1;
        for (int i = RQ - 1; i >= 0; i--) begin
            if (rd_valid[i]) old_i = i;
            if (rd_valid[i] && row_open && rd_row[i*RW +: RW] == open_row) hit_i = i;
        end
        for (int i = WQ - 1; i >= 0; i--) if (wr_valid[i]) w_i = i;
        if (cmdq_busy) begin
            e_tag = "R1";
        end else if (old_i < 0 && w_i < 0) begin
            e_tag = "R2";
        end else if (drain_mode && w_i >= 0) begin
            e_tag = "R3";
            c = exp_cmd(wr_row[w_i*RW +: RW], 1'b1);
            if (exp_ready(c)) begin
                e_valid = 1; e_wr = 1; e_cmd = c; e_idx = IW'(w_i);
            end
        end else if (drain_mode && !cfg_read_bypass) begin
            e_tag = "R4";
        end else if (old_i < 0) begin
            e_tag = "R5";
        end else begin
            lim  = {1'b0, act_ts} + {1'b0, t_ras};
            spec = {1'b0, now_cyc} + {1'b0, t_rtp};
            e_tag = "R6";
            e_idx = IW'(old_i);
            if (cfg_hit_bypass && hit_i >= 0 && hit_i != old_i && spec <= lim) begin
                e_idx = IW'(hit_i);
                e_byp = 1;
                e_tag = "R7";
            end
            c = exp_cmd(rd_row[int'(e_idx)*RW +: RW], 1'b0);
            if (exp_ready(c)) begin
                e_valid = 1; e_cmd = c;
            end else begin
                e_valid = 0; e_byp = 0; e_idx = 0; e_tag = "R10";
            end
        end
    endtask

    task automatic check_out(input string tag);
        n_checks++;
        if ({sel_valid, sel_is_write, sel_bypass, sel_cmd, sel_idx} !==
            {e_valid, e_wr, e_byp, e_cmd, e_idx}) begin
            n_fail++;
            $display("FAIL %s: got v=%0b w=%0b b=%0b cmd=%0d idx=%0d, exp v=%0b w=%0b b=%0b cmd=%0d idx=%0d",
                     tag, sel_valid, sel_is_write, sel_bypass, sel_cmd, sel_idx,
                     e_valid, e_wr, e_byp, e_cmd, e_idx);
        end
    endtask

    // inputs are driven 1 time unit after an edge; result checked after the next
    task automatic step(input string tag);
        model();
        @(posedge clk);
        #1;
        check_out(tag == "" ? e_tag : tag);
    endtask

    task automatic clear_in();
        cmdq_busy = 0; drain_mode = 0; cfg_read_bypass = 0; cfg_hit_bypass = 0;
        rd_valid = 0; rd_row = 0; wr_valid = 0; wr_row = 0;
        row_open = 1; open_row = 8'd5; act_ts = 16'd100; now_cyc = 16'd120;
        t_ras = 16'd30; t_rtp = 16'd5;
        can_act = 1; can_pre = 1; can_rd = 1; can_wr = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        clear_in();
        rd_valid = 8'hFF;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state is all zero
        e_valid = 0; e_wr = 0; e_byp = 0; e_cmd = 0; e_idx = 0;
        check_out("R11 reset");
        rst_n = 1;

        // R1: busy bank
        clear_in(); rd_valid = 8'h01; rd_row[0 +: 8] = 8'd5; cmdq_busy = 1;
        step("R1 busy");
        // R2: empty queues
        clear_in(); step("R2 empty");
        // R3: drain picks oldest write 3, row open -> write cmd 3
        clear_in(); drain_mode = 1; wr_valid = 8'h28;
        wr_row[3*8 +: 8] = 8'd5; wr_row[5*8 +: 8] = 8'd9; rd_valid = 8'h01;
        step("R3 drain write");
        // R3: write not ready, no read fallback
        can_wr = 0; cfg_read_bypass = 1; rd_row[0 +: 8] = 8'd5;
        step("R3 write blocked");
        // R4: drain, no writes, bypass off then on
        clear_in(); drain_mode = 1; rd_valid = 8'h04; rd_row[2*8 +: 8] = 8'd5;
        step("R4 read blocked");
        cfg_read_bypass = 1; step("R4 read allowed");
        // R5: normal mode with only writes
        clear_in(); wr_valid = 8'h01; wr_row[0 +: 8] = 8'd5; step("R5 writes ignored");
        // R6/R9: oldest read slot 2, bank closed -> activate
        clear_in(); row_open = 0; rd_valid = 8'hC4; step("R6 R9 activate");
        // R9: row conflict -> precharge
        clear_in(); rd_valid = 8'h02; rd_row[1*8 +: 8] = 8'd7; step("R9 precharge");
        // R10: precharge not ready
        can_pre = 0; step("R10 blocked");
        // R7/R8: miss at slot 0, hit at slot 4, window exactly equal
        clear_in(); cfg_hit_bypass = 1; rd_valid = 8'h11;
        rd_row[0 +: 8] = 8'd7; rd_row[4*8 +: 8] = 8'd5;
        act_ts = 16'd100; t_ras = 16'd30; now_cyc = 16'd125; t_rtp = 16'd5;
        step("R8 window equal");
        now_cyc = 16'd126; step("R8 window late");
        // R8: sums past counter width
        act_ts = 16'hFFF0; t_ras = 16'h0020; now_cyc = 16'hFFF8; t_rtp = 16'd4;
        step("R8 wide sum");
        // R7: bypass disabled
        cfg_hit_bypass = 0; now_cyc = 16'd110; act_ts = 16'd100; step("R7 disabled");
        // R12: oldest already hits, no bypass flag
        cfg_hit_bypass = 1; rd_row[0 +: 8] = 8'd5; step("R12 oldest hits");

        // random stimulus
        for (int n = 0; n < 3000; n++) begin
            logic [TW-1:0] base;
            cmdq_busy       = ($urandom % 10) == 0;
            drain_mode      = ($urandom % 5) < 2;
            cfg_read_bypass = $urandom % 2;
            cfg_hit_bypass  = ($urandom % 10) < 7;
            rd_valid = (($urandom % 8) == 0) ? 8'h00 : 8'($urandom);
            wr_valid = (($urandom % 3) == 0) ? 8'h00 : 8'($urandom);
            for (int i = 0; i < RQ; i++) rd_row[i*RW +: RW] = 8'($urandom % 4);
            for (int i = 0; i < WQ; i++) wr_row[i*RW +: RW] = 8'($urandom % 4);
            row_open = ($urandom % 5) != 0;
            open_row = 8'($urandom % 4);
            base     = 16'($urandom);
            now_cyc  = base;
            act_ts   = base - 16'($urandom % 64);
            t_ras    = 16'($urandom % 64);
            t_rtp    = 16'($urandom % 16);
            can_act  = ($urandom % 5) != 0;
            can_pre  = ($urandom % 5) != 0;
            can_rd   = ($urandom % 5) != 0;
            can_wr   = ($urandom % 5) != 0;
            step("");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule